// File: doc/BRIEF.md
# Control Transfer Resolution Unit

This block settles every control transfer of a 32-bit integer pipeline in one registered stage. Each cycle it may take one decoded transfer: the program counter of the instruction, the transfer kind, the comparison selector, two register operands, the sign-extended immediate and the destination register index. One clock later it presents the results:
- whether the transfer is taken;
- the computed target and the next PC;
- the static prediction that decode made;
- a redirect flag for the fetch unit;
- the return address and its write enable;
- flags for a misaligned target and an illegal comparison code.

Conditional branches compare the two operands directly; no flag register is involved. Decode swaps the operands to get greater-than and less-or-equal, so the unit only sees six comparisons. The static prediction treats a backward branch as taken. There is no delay slot, so a redirect tells fetch to drop the instruction that follows a mispredicted transfer. Direct jumps are predicted taken. Register-indirect jumps have no target at decode, so they are predicted not taken.

Top module: `xfer_resolve`

## Requirements
- R1: For kind_i = 01 (conditional branch), taken_o reports the comparison chosen by sel_i: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal.
- R2: A conditional branch with sel_i 010 or 011 raises illegal_o, is not taken, and raises neither redirect_o nor link_we_o.
- R3: A conditional branch target is pc_i plus imm_i with bit 0 of the sum cleared. next_pc_o is target_o when the transfer is taken and free of exceptions; otherwise it is pc_i + 4.
- R4: pred_o is imm_i[31] for a conditional branch, 1 for a direct jump (kind_i = 10) and 0 for a register jump (kind_i = 11) or no transfer (kind_i = 00).
- R5: redirect_o is raised exactly when a transfer without exception resolves to a direction that differs from pred_o. A direct jump therefore never redirects, and a register jump without exception always does.
- R6: A direct jump is always taken, and its target is pc_i plus imm_i with bit 0 cleared.
- R7: A register jump is always taken, and its target is rs1_i plus imm_i with bit 0 cleared.
- R8: A taken transfer whose target has bit 1 set raises misalign_o and suppresses redirect_o and link_we_o. next_pc_o is then pc_i + 4. A not-taken branch never raises misalign_o.
- R9: link_o is pc_i + 4. link_we_o is raised only for a direct or register jump with rd_i not zero and no misaligned target.
- R10: Results appear one clock after the input cycle. When valid_i was low, or during reset, valid_o and all flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A transfer is presented this cycle |
| kind_i | input | 2 | 00 none, 01 conditional branch, 10 direct jump, 11 register jump |
| sel_i | input | 3 | Comparison selector for conditional branches |
| pc_i | input | 32 | PC of the transfer instruction |
| rs1_i | input | 32 | First operand, also the register-jump base |
| rs2_i | input | 32 | Second operand |
| imm_i | input | 32 | Sign-extended offset |
| rd_i | input | 5 | Destination register index for the return address |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Resolved direction |
| target_o | output | 32 | Computed target |
| next_pc_o | output | 32 | Address fetch should continue from |
| pred_o | output | 1 | Static prediction made at decode |
| redirect_o | output | 1 | Prediction was wrong, so fetch must restart at next_pc_o |
| link_o | output | 32 | Return address |
| link_we_o | output | 1 | Write link_o to rd |
| misalign_o | output | 1 | Taken target is not 4-byte aligned |
| illegal_o | output | 1 | Reserved comparison selector |

## Verification
The assertions assume that kind_i, sel_i and rd_i are known whenever valid_i is high. They also assume that imm_i is already sign-extended from its instruction field, so bit 31 carries the offset's sign. The stimulus drives only full 32-bit sign-extended offsets, changes inputs only on the falling edge, and holds valid_i low at reset. It covers operand pairs on both sides of the signed and unsigned boundaries, including 0x80000000 against 0x7FFFFFFF. Targets include odd offsets whose bit 0 must be dropped, and targets with bit 1 set that must trap.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_BR   = 2'b01,
    KIND_JMP  = 2'b10,
    KIND_JREG = 2'b11
  } kind_e;

  localparam logic [2:0] SEL_EQ  = 3'b000;
  localparam logic [2:0] SEL_NE  = 3'b001;
  localparam logic [2:0] SEL_LT  = 3'b100;
  localparam logic [2:0] SEL_GE  = 3'b101;
  localparam logic [2:0] SEL_LTU = 3'b110;
  localparam logic [2:0] SEL_GEU = 3'b111;
endpackage

// File: rtl/xfer_cmp.sv
module xfer_cmp #(
  parameter int XLEN       = 32,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      sel_i,
  output logic            hit_o,
  output logic            bad_sel_o
);
  import xfer_pkg::*;

  logic eq, lt, ltu;

  generate
    if (SHARED_SUB) begin : g_sub
      // one borrow chain serves all three relations
      logic [XLEN:0] diff;
      assign diff = {1'b0, a_i} - {1'b0, b_i};
      assign ltu  = diff[XLEN];
      assign eq   = (diff[XLEN-1:0] == '0);
      assign lt   = (a_i[XLEN-1] ^ b_i[XLEN-1]) ? a_i[XLEN-1] : diff[XLEN];
    end else begin : g_direct
      assign eq  = (a_i == b_i);
      assign ltu = (a_i < b_i);
      assign lt  = ($signed(a_i) < $signed(b_i));
    end
  endgenerate

  always_comb begin
    hit_o     = 1'b0;
    bad_sel_o = 1'b0;
    unique case (sel_i)
      SEL_EQ:  hit_o = eq;
      SEL_NE:  hit_o = ~eq;
      SEL_LT:  hit_o = lt;
      SEL_GE:  hit_o = ~lt;
      SEL_LTU: hit_o = ltu;
      SEL_GEU: hit_o = ~ltu;
      default: bad_sel_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/xfer_addr.sv
module xfer_addr #(
  parameter int XLEN       = 32,
  parameter int ILEN_BYTES = 4
) (
  input  xfer_pkg::kind_e kind_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_o,
  output logic            odd_o
);
  import xfer_pkg::*;

  localparam int ALIGN_W = $clog2(ILEN_BYTES);

  logic [XLEN-1:0] base, sum;

  assign base     = (kind_i == KIND_JREG) ? rs1_i : pc_i;
  assign sum      = base + imm_i;
  assign target_o = {sum[XLEN-1:1], 1'b0};
  assign link_o   = pc_i + XLEN'(ILEN_BYTES);
  // bit 0 is already cleared; check the remaining alignment bits
  assign odd_o    = |target_o[ALIGN_W-1:1];
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl #(
  parameter int RIDX_W = 5
) (
  input  xfer_pkg::kind_e    kind_i,
  input  logic               hit_i,
  input  logic               bad_sel_i,
  input  logic               odd_i,
  input  logic               imm_sign_i,
  input  logic [RIDX_W-1:0]  rd_i,
  output logic               taken_o,
  output logic               pred_o,
  output logic               redirect_o,
  output logic               link_we_o,
  output logic               misalign_o,
  output logic               illegal_o,
  output logic               use_target_o
);
  import xfer_pkg::*;

  logic is_br, is_jump, exc;

  assign is_br   = (kind_i == KIND_BR);
  assign is_jump = (kind_i == KIND_JMP) || (kind_i == KIND_JREG);

  always_comb begin
    taken_o = 1'b0;
    pred_o  = 1'b0;
    unique case (kind_i)
      KIND_BR:   begin taken_o = hit_i & ~bad_sel_i; pred_o = imm_sign_i; end
      KIND_JMP:  begin taken_o = 1'b1;               pred_o = 1'b1;       end
      KIND_JREG: begin taken_o = 1'b1;               pred_o = 1'b0;       end
      default:   begin taken_o = 1'b0;               pred_o = 1'b0;       end
    endcase
  end

  assign illegal_o    = is_br & bad_sel_i;
  assign misalign_o   = taken_o & odd_i;
  assign exc          = illegal_o | misalign_o;
  assign redirect_o   = (kind_i != KIND_NONE) & ~exc & (taken_o != pred_o);
  assign link_we_o    = is_jump & (rd_i != '0) & ~misalign_o;
  assign use_target_o = taken_o & ~exc;
endmodule

// File: rtl/xfer_resolve.sv
module xfer_resolve #(
  parameter int XLEN       = 32,
  parameter int RIDX_W     = 5,
  parameter int ILEN_BYTES = 4,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        kind_i,
  input  logic [2:0]        sel_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   rs1_i,
  input  logic [XLEN-1:0]   rs2_i,
  input  logic [XLEN-1:0]   imm_i,
  input  logic [RIDX_W-1:0] rd_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   target_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              pred_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   link_o,
  output logic              link_we_o,
  output logic              misalign_o,
  output logic              illegal_o
);
  import xfer_pkg::*;

  kind_e           kind;
  logic            hit, bad_sel, odd;
  logic [XLEN-1:0] tgt_c, link_c;
  logic            taken_c, pred_c, redir_c, we_c, mis_c, ill_c, use_tgt_c;

  assign kind = kind_e'(kind_i);

  xfer_cmp #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cmp (
    .a_i(rs1_i), .b_i(rs2_i), .sel_i(sel_i), .hit_o(hit), .bad_sel_o(bad_sel)
  );

  xfer_addr #(.XLEN(XLEN), .ILEN_BYTES(ILEN_BYTES)) u_addr (
    .kind_i(kind), .pc_i(pc_i), .rs1_i(rs1_i), .imm_i(imm_i),
    .target_o(tgt_c), .link_o(link_c), .odd_o(odd)
  );

  xfer_ctrl #(.RIDX_W(RIDX_W)) u_ctrl (
    .kind_i(kind), .hit_i(hit), .bad_sel_i(bad_sel), .odd_i(odd),
    .imm_sign_i(imm_i[XLEN-1]), .rd_i(rd_i),
    .taken_o(taken_c), .pred_o(pred_c), .redirect_o(redir_c),
    .link_we_o(we_c), .misalign_o(mis_c), .illegal_o(ill_c),
    .use_target_o(use_tgt_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      taken_o    <= 1'b0;
      pred_o     <= 1'b0;
      redirect_o <= 1'b0;
      link_we_o  <= 1'b0;
      misalign_o <= 1'b0;
      illegal_o  <= 1'b0;
      target_o   <= '0;
      next_pc_o  <= '0;
      link_o     <= '0;
    end else begin
      valid_o    <= valid_i;
      taken_o    <= valid_i & taken_c;
      pred_o     <= valid_i & pred_c;
      redirect_o <= valid_i & redir_c;
      link_we_o  <= valid_i & we_c;
      misalign_o <= valid_i & mis_c;
      illegal_o  <= valid_i & ill_c;
      target_o   <= tgt_c;
      next_pc_o  <= use_tgt_c ? tgt_c : link_c;
      link_o     <= link_c;
    end
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(taken_o || pred_o || redirect_o || link_we_o || misalign_o || illegal_o));

  // R8
  misalign_no_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (!link_we_o && !redirect_o && next_pc_o == link_o && target_o[1]));

  // R3
  next_pc_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !misalign_o && !illegal_o) |-> (next_pc_o == (taken_o ? target_o : link_o)));

  // R9
  link_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rd_i == '0) |=> !link_we_o);

  // R9
  link_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (link_o == $past(pc_i) + XLEN'(ILEN_BYTES)));

  // R5
  jmp_no_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == KIND_JMP) |=> !redirect_o);

  // R2
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!taken_o && !redirect_o && !link_we_o));

  // R7
  target_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !target_o[0]);
endmodule

// File: tb/xfer_resolve_tb.sv
module xfer_resolve_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [2:0]  sel_i = '0;
  logic [31:0] pc_i = '0, rs1_i = '0, rs2_i = '0, imm_i = '0;
  logic [4:0]  rd_i = '0;
  logic        valid_o, taken_o, pred_o, redirect_o, link_we_o, misalign_o, illegal_o;
  logic [31:0] target_o, next_pc_o, link_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_resolve u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .kind_i(kind_i), .sel_i(sel_i),
    .pc_i(pc_i), .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i), .rd_i(rd_i),
    .valid_o(valid_o), .taken_o(taken_o), .target_o(target_o), .next_pc_o(next_pc_o),
    .pred_o(pred_o), .redirect_o(redirect_o), .link_o(link_o), .link_we_o(link_we_o),
    .misalign_o(misalign_o), .illegal_o(illegal_o)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  sel;
    logic [31:0] pc, a, b, imm;
    logic [4:0]  rd;
    logic        tk, pr, rdr, we, mis, ill;
    logic [31:0] tgt;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    // R1 R3 R5: eq taken forward, mispredicted
    '{2'b01, 3'b000, 32'h1000, 32'd5, 32'd5, 32'h10, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1010},
    // R1 R4: ne not taken backward
    '{2'b01, 3'b001, 32'h1000, 32'd5, 32'd5, 32'hFFFF_FFF8, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0FF8},
    '{2'b01, 3'b100, 32'h1000, 32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFF0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0FF0},
    '{2'b01, 3'b110, 32'h1000, 32'hFFFF_FFFF, 32'd1, 32'h20, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1020},
    '{2'b01, 3'b101, 32'h1000, 32'd1, 32'hFFFF_FFFF, 32'h8, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1008},
    '{2'b01, 3'b111, 32'h1000, 32'd1, 32'hFFFF_FFFF, 32'h8, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1008},
    '{2'b01, 3'b101, 32'h1000, 32'd7, 32'd7, 32'hFFFF_FFFC, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0FFC},
    '{2'b01, 3'b100, 32'h1000, 32'h8000_0000, 32'h7FFF_FFFF, 32'h4, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1004},
    // R2 reserved selectors
    '{2'b01, 3'b010, 32'h1000, 32'd1, 32'd2, 32'h4, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1004},
    '{2'b01, 3'b011, 32'h1000, 32'd1, 32'd2, 32'hFFFF_FFF0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0FF0},
    // R8 taken branch misaligned; not-taken one is not
    '{2'b01, 3'b000, 32'h1000, 32'd5, 32'd5, 32'h6, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1006},
    '{2'b01, 3'b001, 32'h1000, 32'd5, 32'd5, 32'h6, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1006},
    // R3 offset bit 0 ignored
    '{2'b01, 3'b000, 32'h1000, 32'd3, 32'd3, 32'h11, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1010},
    // R6 direct jumps
    '{2'b10, 3'b000, 32'h1000, 32'd0, 32'd0, 32'h100, 5'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1100},
    '{2'b10, 3'b000, 32'h1000, 32'd0, 32'd0, 32'hFFFF_F800, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0800},
    '{2'b10, 3'b000, 32'h1000, 32'd0, 32'd0, 32'h2, 5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1002},
    // R7 register jumps
    '{2'b11, 3'b000, 32'h4000, 32'h2001, 32'd0, 32'h4, 5'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h2004},
    '{2'b11, 3'b000, 32'h1000, 32'h3000, 32'd0, 32'h0, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h3000},
    '{2'b11, 3'b000, 32'h1000, 32'h2003, 32'd0, 32'h0, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h2002},
    '{2'b11, 3'b000, 32'h1000, 32'h10, 32'd0, 32'hFFFF_FFF0, 5'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000},
    // no transfer
    '{2'b00, 3'b000, 32'h1000, 32'd5, 32'd5, 32'h0, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1000}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    valid_i = vld; kind_i = v.kind; sel_i = v.sel; pc_i = v.pc;
    rs1_i = v.a; rs2_i = v.b; imm_i = v.imm; rd_i = v.rd;
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset valid_o", 32'(valid_o), 32'd0);
    chk("R10 reset redirect_o", 32'(redirect_o), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] nxt;
      v = VECS[i];
      @(negedge clk);
      drive(v, 1'b1);
      @(negedge clk);
      nxt = (v.tk && !v.mis && !v.ill) ? v.tgt : v.pc + 32'd4;
      chk($sformatf("R10 vec %0d valid_o", i), 32'(valid_o), 32'd1);
      chk($sformatf("R1 vec %0d taken_o", i), 32'(taken_o), 32'(v.tk));
      chk($sformatf("R3/R6/R7 vec %0d target_o", i), target_o, v.tgt);
      chk($sformatf("R3 vec %0d next_pc_o", i), next_pc_o, nxt);
      chk($sformatf("R4 vec %0d pred_o", i), 32'(pred_o), 32'(v.pr));
      chk($sformatf("R5 vec %0d redirect_o", i), 32'(redirect_o), 32'(v.rdr));
      chk($sformatf("R9 vec %0d link_we_o", i), 32'(link_we_o), 32'(v.we));
      chk($sformatf("R9 vec %0d link_o", i), link_o, v.pc + 32'd4);
      chk($sformatf("R8 vec %0d misalign_o", i), 32'(misalign_o), 32'(v.mis));
      chk($sformatf("R2 vec %0d illegal_o", i), 32'(illegal_o), 32'(v.ill));
    end

    // R10 transfer presented with valid_i low leaves flags clear
    @(negedge clk);
    drive(VECS[13], 1'b0);
    @(negedge clk);
    chk("R10 idle valid_o", 32'(valid_o), 32'd0);
    chk("R10 idle link_we_o", 32'(link_we_o), 32'd0);
    chk("R10 idle taken_o", 32'(taken_o), 32'd0);

    // R10 asynchronous reset mid-run
    drive(VECS[16], 1'b1);
    @(negedge clk);
    chk("R5 pre-reset redirect_o", 32'(redirect_o), 32'd1);
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async reset redirect_o", 32'(redirect_o), 32'd0);
    chk("R10 async reset link_we_o", 32'(link_we_o), 32'd0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset valid_o", 32'(valid_o), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule